// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block holds the time of day and the calendar date as packed BCD digit pairs (seconds, minutes, hours, day of month, month and a two-digit year) and a seven-state weekday counter. The weekday counter is not tied to any calendar rule. Each accepted 1 Hz tick advances the seconds, and carries ripple upward through minutes, hours, days, months and years. Month lengths are applied, and February has a leap day in every year value that is divisible by four.

A host reaches the block through a narrow 4-bit register port. Each digit can be loaded on its own. Two control registers select 12-hour or 24-hour counting, stop the counter, pin the seconds at zero, and defer ticks while the host reads a coherent value. A one-shot command rounds the time to the nearest minute: it clears the seconds and carries into the minutes when the seconds were 30 or more. Reads are combinational from the stored state. Writes and ticks take effect at the rising clock edge.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset the registers read 00:00:00, day 01, month 01, year 00 and weekday 0. Register 0xF reads 0100 (24-hour mode, not stopped, not cleared) and register 0xD reads 0000. Map: 0x0/0x1 second ones/tens, 0x2/0x3 minute ones/tens, 0x4/0x5 hour ones/tens (0x5 bit2 = PM), 0x6/0x7 day, 0x8/0x9 month, 0xA/0xB year, 0xC weekday, 0xD control (bit3 adjust, bit1 busy, bit0 hold), 0xE reads 0, 0xF control (bit3 ignored, bit2 24-hour, bit1 stop, bit0 clear).
- R2: An accepted tick adds one to the seconds in BCD, and the new value is readable after that clock edge. Seconds 59 wrap to 00 and carry one into the minutes.
- R3: Minutes 59 wrap to 00 and carry into the hours. In 24-hour mode hours 23 wrap to 00 and carry into the day.
- R4: In 12-hour mode (0xF bit2 = 0) the hours run 12, 01 … 11. The PM bit toggles on the 11→12 step, and 11 PM → 12 AM carries into the day. In 24-hour mode the PM bit reads 0.
- R5: The day wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 for month 02, or 29 when the year value is divisible by 4 (including 00). The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R6: The weekday counts 0…6 and steps once each time the day steps, wrapping from 6 to 0.
- R7: Writing register 0xD with bit3 = 1 clears the seconds to 00 at that edge. If the seconds were 30 or more, it also adds one minute, with full carry. Bit3 always reads 0.
- R8: While stop (0xF bit1) is set, ticks are discarded and are not replayed when stop is cleared.
- R9: While clear (0xF bit0) is set, the seconds are forced to 00 from the next edge on, and ticks are discarded.
- R10: While hold (0xD bit0) is set, the time does not change and ticks are deferred. At most one tick is kept, and busy (0xD bit1) reads 1 while one is kept. The kept tick is applied at the first edge after hold clears.
- R11: A digit write loads only the bits that exist for that digit, and the other bits read 0. A tick that arrives together with any write is kept and applied at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 4 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 4 | Read data, combinational |

## Verification
A tick or a write takes effect at the edge where it is sampled. Reads are combinational, so every result is checked on the falling edge right after that edge. There are three exceptions. The clear function pins the seconds one edge after its write. A tick that arrives with a write lands one edge later. A tick kept under hold lands at the first edge after the write that clears hold. The bench drives every stimulus on a falling edge and advances exactly the number of edges that the matching requirement names before it reads.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [2:0] wkd;
    logic       pm;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tk_time_t;

  localparam logic [3:0] A_SEC1  = 4'h0;
  localparam logic [3:0] A_SEC10 = 4'h1;
  localparam logic [3:0] A_MIN1  = 4'h2;
  localparam logic [3:0] A_MIN10 = 4'h3;
  localparam logic [3:0] A_HR1   = 4'h4;
  localparam logic [3:0] A_HR10  = 4'h5;
  localparam logic [3:0] A_DAY1  = 4'h6;
  localparam logic [3:0] A_DAY10 = 4'h7;
  localparam logic [3:0] A_MON1  = 4'h8;
  localparam logic [3:0] A_MON10 = 4'h9;
  localparam logic [3:0] A_YR1   = 4'hA;
  localparam logic [3:0] A_YR10  = 4'hB;
  localparam logic [3:0] A_WKD   = 4'hC;
  localparam logic [3:0] A_CTLD  = 4'hD;
  localparam logic [3:0] A_CTLF  = 4'hF;

  localparam int CD_ADJ  = 3;
  localparam int CD_BUSY = 1;
  localparam int CD_HOLD = 0;
  localparam int CF_24H  = 2;
  localparam int CF_STOP = 1;
  localparam int CF_CLR  = 0;

  localparam logic [2:0] WKD_LAST = 3'd6;

  // BCD increment of a digit pair (no wrap; caller handles the limit)
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Binary value of a BCD digit pair
  function automatic logic [6:0] bcd_val(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr_bcd);
    logic [6:0] b;
    b = bcd_val(yr_bcd);
    return (b[1:0] == 2'b00);
  endfunction

  // Last day of the month, BCD
  function automatic logic [7:0] month_end(input logic [7:0] mon_bcd,
                                           input logic [7:0] yr_bcd);
    logic [7:0] r;
    case (mon_bcd)
      8'h02:                     r = is_leap(yr_bcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                   r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tk_tick_gate.sv
module tk_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic halt,
  input  logic clr,
  input  logic bus_wr,
  output logic advance,
  output logic pending
);
  logic tick_ok;
  logic want;
  logic pend_q;
  logic pend_d;

  assign tick_ok = tick & ~halt & ~clr;
  assign want    = tick_ok | pend_q;
  assign advance = want & ~hold & ~halt & ~clr & ~bus_wr;

  always_comb begin
    if (advance) pend_d = pend_q & tick_ok;
    else         pend_d = want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/tk_chain.sv
module tk_chain
  import tk_pkg::*;
(
  input  tk_time_t cur,
  input  logic     mode24,
  input  logic     step_sec,
  input  logic     adj,
  output tk_time_t nxt,
  output logic     ev_min,
  output logic     ev_hr,
  output logic     ev_day,
  output logic     ev_mon,
  output logic     ev_yr
);
  always_comb begin
    nxt    = cur;
    ev_min = 1'b0;
    ev_hr  = 1'b0;
    ev_day = 1'b0;
    ev_mon = 1'b0;
    ev_yr  = 1'b0;

    // seconds
    if (adj) begin
      nxt.sec = 8'h00;
      ev_min  = (cur.sec >= 8'h30);
    end else if (step_sec) begin
      if (cur.sec == 8'h59) begin
        nxt.sec = 8'h00;
        ev_min  = 1'b1;
      end else begin
        nxt.sec = bcd_next(cur.sec);
      end
    end

    // minutes
    if (ev_min) begin
      if (cur.min == 8'h59) begin
        nxt.min = 8'h00;
        ev_hr   = 1'b1;
      end else begin
        nxt.min = bcd_next(cur.min);
      end
    end

    // hours
    if (ev_hr) begin
      if (mode24) begin
        nxt.pm = 1'b0;
        if (cur.hr == 8'h23) begin
          nxt.hr = 8'h00;
          ev_day = 1'b1;
        end else begin
          nxt.hr = bcd_next(cur.hr);
        end
      end else begin
        if (cur.hr == 8'h11) begin
          nxt.hr = 8'h12;
          nxt.pm = ~cur.pm;
          ev_day = cur.pm;
        end else if (cur.hr == 8'h12) begin
          nxt.hr = 8'h01;
        end else begin
          nxt.hr = bcd_next(cur.hr);
        end
      end
    end

    // day and weekday
    if (ev_day) begin
      nxt.wkd = (cur.wkd == WKD_LAST) ? 3'd0 : cur.wkd + 3'd1;
      if (cur.day == month_end(cur.mon, cur.yr)) begin
        nxt.day = 8'h01;
        ev_mon  = 1'b1;
      end else begin
        nxt.day = bcd_next(cur.day);
      end
    end

    // month
    if (ev_mon) begin
      if (cur.mon == 8'h12) begin
        nxt.mon = 8'h01;
        ev_yr   = 1'b1;
      end else begin
        nxt.mon = bcd_next(cur.mon);
      end
    end

    // year
    if (ev_yr) begin
      nxt.yr = (cur.yr == 8'h99) ? 8'h00 : bcd_next(cur.yr);
    end
  end
endmodule

// File: rtl/tk_readmux.sv
module tk_readmux
  import tk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  tk_time_t            t,
  input  logic                mode24,
  input  logic                halt,
  input  logic                clr,
  input  logic                hold,
  input  logic                busy,
  input  logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   data
);
  logic [3:0] v;

  always_comb begin
    v = 4'h0;
    case (addr)
      A_SEC1:  v = t.sec[3:0];
      A_SEC10: v = {1'b0, t.sec[6:4]};
      A_MIN1:  v = t.min[3:0];
      A_MIN10: v = {1'b0, t.min[6:4]};
      A_HR1:   v = t.hr[3:0];
      A_HR10:  v = {1'b0, t.pm & ~mode24, t.hr[5:4]};
      A_DAY1:  v = t.day[3:0];
      A_DAY10: v = {2'b00, t.day[5:4]};
      A_MON1:  v = t.mon[3:0];
      A_MON10: v = {3'b000, t.mon[4]};
      A_YR1:   v = t.yr[3:0];
      A_YR10:  v = t.yr[7:4];
      A_WKD:   v = {1'b0, t.wkd};
      A_CTLD: begin
        v          = 4'h0;
        v[CD_BUSY] = busy;
        v[CD_HOLD] = hold;
      end
      A_CTLF: begin
        v          = 4'h0;
        v[CF_24H]  = mode24;
        v[CF_STOP] = halt;
        v[CF_CLR]  = clr;
      end
      default: v = 4'h0;
    endcase
  end

  generate
    if (DATA_W > 4) begin : g_wide
      assign data = {{(DATA_W-4){1'b0}}, v};
    end else begin : g_narrow
      assign data = v[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
  import tk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam tk_time_t RESET_TIME = '{yr: 8'h00, mon: 8'h01, day: 8'h01,
                                      wkd: 3'd0, pm: 1'b0, hr: 8'h00,
                                      min: 8'h00, sec: 8'h00};

  tk_time_t   time_q;
  tk_time_t   chain_nxt;
  logic       mode24_q, halt_q, clr_q, hold_q;
  logic       advance, pending;
  logic       adj_cmd;
  logic       ev_min, ev_hr, ev_day, ev_mon, ev_yr;
  logic [3:0] wd;

  assign wd      = wr_data[3:0];
  assign adj_cmd = wr_en && (wr_addr == A_CTLD) && wd[CD_ADJ];

  tk_tick_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1hz),
    .hold   (hold_q),
    .halt   (halt_q),
    .clr    (clr_q),
    .bus_wr (wr_en),
    .advance(advance),
    .pending(pending)
  );

  tk_chain u_chain (
    .cur     (time_q),
    .mode24  (mode24_q),
    .step_sec(advance),
    .adj     (adj_cmd),
    .nxt     (chain_nxt),
    .ev_min  (ev_min),
    .ev_hr   (ev_hr),
    .ev_day  (ev_day),
    .ev_mon  (ev_mon),
    .ev_yr   (ev_yr)
  );

  tk_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .t     (time_q),
    .mode24(mode24_q),
    .halt  (halt_q),
    .clr   (clr_q),
    .hold  (hold_q),
    .busy  (pending),
    .addr  (rd_addr),
    .data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q   <= RESET_TIME;
      mode24_q <= 1'b1;
      halt_q   <= 1'b0;
      clr_q    <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_SEC1:  time_q.sec[3:0] <= wd;
          A_SEC10: time_q.sec[7:4] <= {1'b0, wd[2:0]};
          A_MIN1:  time_q.min[3:0] <= wd;
          A_MIN10: time_q.min[7:4] <= {1'b0, wd[2:0]};
          A_HR1:   time_q.hr[3:0]  <= wd;
          A_HR10: begin
            time_q.hr[7:4] <= {2'b00, wd[1:0]};
            time_q.pm      <= wd[2] & ~mode24_q;
          end
          A_DAY1:  time_q.day[3:0] <= wd;
          A_DAY10: time_q.day[7:4] <= {2'b00, wd[1:0]};
          A_MON1:  time_q.mon[3:0] <= wd;
          A_MON10: time_q.mon[7:4] <= {3'b000, wd[0]};
          A_YR1:   time_q.yr[3:0]  <= wd;
          A_YR10:  time_q.yr[7:4]  <= wd;
          A_WKD:   time_q.wkd      <= wd[2:0];
          A_CTLD: begin
            hold_q <= wd[CD_HOLD];
            if (adj_cmd) time_q <= chain_nxt;
          end
          A_CTLF: begin
            mode24_q <= wd[CF_24H];
            halt_q   <= wd[CF_STOP];
            clr_q    <= wd[CF_CLR];
          end
          default: ;
        endcase
      end else if (advance) begin
        time_q <= chain_nxt;
      end
      if (clr_q) time_q.sec <= 8'h00;
    end
  end
endmodule

// File: rtl/tk_checker.sv
module tk_checker
  import tk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input tk_time_t   time_q,
  input logic       advance,
  input logic       hold_q,
  input logic       halt_q,
  input logic       clr_q,
  input logic       mode24_q,
  input logic       ev_day,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [3:0] wr_data,
  input logic [3:0] rd_addr,
  input logic [3:0] rd_data
);
  // R2: seconds stay a legal BCD pair
  a_r2_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.sec[3:0] <= 4'd9) && (time_q.sec[7:4] <= 4'd5));

  // R3: minutes stay a legal BCD pair
  a_r3_min_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.min[3:0] <= 4'd9) && (time_q.min[7:4] <= 4'd5));

  // R2: an accepted step always changes the seconds
  a_r2_step_moves_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clr_q) |=> (time_q.sec != $past(time_q.sec)));

  // R6: weekday range and stepping with the day
  a_r6_wkd_range: assert property (@(posedge clk) disable iff (!rst_n)
    time_q.wkd <= WKD_LAST);
  a_r6_wkd_follows_day: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day |=> (time_q.wkd != $past(time_q.wkd)));

  // R4: PM bit hidden in 24-hour mode
  a_r4_pm_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (mode24_q && rd_addr == A_HR10) |-> !rd_data[2]);

  // R7: adjust command leaves seconds at zero
  a_r7_adj_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTLD && wr_data[CD_ADJ]) |=> (time_q.sec == 8'h00));

  // R8: stop freezes the time when the bus is idle
  a_r8_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en && !clr_q) |=> $stable(time_q));

  // R10: hold freezes the time when the bus is idle
  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_en && !clr_q) |=> $stable(time_q));

  // R9: clear pins the seconds
  a_r9_clear_pins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (time_q.sec == 8'h00));
endmodule

bind tk_timekeeper tk_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .time_q  (time_q),
  .advance (advance),
  .hold_q  (hold_q),
  .halt_q  (halt_q),
  .clr_q   (clr_q),
  .mode24_q(mode24_q),
  .ev_day  (ev_day),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/sim_tk_timekeeper.sv
`timescale 1ns/1ps
module sim_tk_timekeeper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] rd_addr = 4'h0;
  logic [3:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tk_timekeeper u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic tk();
    tick_1hz = 1'b1;
    cyc();
    tick_1hz = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd_pair(input logic [3:0] lo, output logic [7:0] v);
    logic [3:0] a, b;
    rd(lo, a);
    rd(lo + 4'h1, b);
    v = {b, a};
  endtask

  task automatic set_time(input logic [7:0] hr, input logic pm,
                          input logic [7:0] mi, input logic [7:0] se);
    wr(4'h0, se[3:0]); wr(4'h1, se[7:4]);
    wr(4'h2, mi[3:0]); wr(4'h3, mi[7:4]);
    wr(4'h4, hr[3:0]); wr(4'h5, {1'b0, pm, hr[5:4]});
  endtask

  task automatic set_date(input logic [7:0] yr, input logic [7:0] mo,
                          input logic [7:0] dy, input logic [2:0] wk);
    wr(4'h6, dy[3:0]); wr(4'h7, dy[7:4]);
    wr(4'h8, mo[3:0]); wr(4'h9, mo[7:4]);
    wr(4'hA, yr[3:0]); wr(4'hB, yr[7:4]);
    wr(4'hC, {1'b0, wk});
  endtask

  task automatic chk_time(input string req, input logic [7:0] hr,
                          input logic pm, input logic [7:0] mi,
                          input logic [7:0] se);
    logic [7:0] v;
    logic [3:0] h10;
    rd_pair(4'h0, v); chk(req, "sec", v, se);
    rd_pair(4'h2, v); chk(req, "min", v, mi);
    rd(4'h4, v[3:0]); rd(4'h5, h10);
    chk(req, "hour", {2'b00, h10[1:0], v[3:0]}, hr);
    chk(req, "pm", {7'd0, h10[2]}, {7'd0, pm});
  endtask

  task automatic chk_date(input string req, input logic [7:0] yr,
                          input logic [7:0] mo, input logic [7:0] dy,
                          input logic [2:0] wk);
    logic [7:0] v;
    logic [3:0] w;
    rd_pair(4'h6, v); chk(req, "day", v, dy);
    rd_pair(4'h8, v); chk(req, "month", v, mo);
    rd_pair(4'hA, v); chk(req, "year", v, yr);
    rd(4'hC, w);      chk(req, "weekday", {4'h0, w}, {5'd0, wk});
  endtask

  // R1: reset state
  task automatic t_reset();
    logic [3:0] v;
    chk_time("R1", 8'h00, 1'b0, 8'h00, 8'h00);
    chk_date("R1", 8'h00, 8'h01, 8'h01, 3'd0);
    rd(4'hF, v); chk("R1", "ctrlF", {4'h0, v}, 8'h04);
    rd(4'hD, v); chk("R1", "ctrlD", {4'h0, v}, 8'h00);
  endtask

  // R2: seconds stepping and minute carry
  task automatic t_seconds();
    set_time(8'h00, 1'b0, 8'h00, 8'h58);
    tk(); chk_time("R2", 8'h00, 1'b0, 8'h00, 8'h59);
    tk(); chk_time("R2", 8'h00, 1'b0, 8'h01, 8'h00);
  endtask

  // R3 and R6: midnight rollover in 24-hour mode
  task automatic t_midnight24();
    set_date(8'h21, 8'h03, 8'h05, 3'd2);
    set_time(8'h23, 1'b0, 8'h59, 8'h59);
    tk();
    chk_time("R3", 8'h00, 1'b0, 8'h00, 8'h00);
    chk_date("R6", 8'h21, 8'h03, 8'h06, 3'd3);
    set_time(8'h09, 1'b0, 8'h59, 8'h59);
    tk(); chk_time("R3", 8'h10, 1'b0, 8'h00, 8'h00);
  endtask

  // R4: 12-hour sequence and PM flag
  task automatic t_twelve();
    logic [3:0] v;
    wr(4'hF, 4'b0000);
    set_date(8'h21, 8'h06, 8'h10, 3'd2);
    set_time(8'h11, 1'b0, 8'h59, 8'h59);
    tk(); chk_time("R4", 8'h12, 1'b1, 8'h00, 8'h00);
    set_time(8'h12, 1'b1, 8'h59, 8'h59);
    tk(); chk_time("R4", 8'h01, 1'b1, 8'h00, 8'h00);
    set_time(8'h11, 1'b1, 8'h59, 8'h59);
    tk(); chk_time("R4", 8'h12, 1'b0, 8'h00, 8'h00);
    chk_date("R4", 8'h21, 8'h06, 8'h11, 3'd3);
    set_time(8'h05, 1'b1, 8'h00, 8'h00);
    wr(4'hF, 4'b0100);
    rd(4'h5, v); chk("R4", "pm hidden in 24h", {7'd0, v[2]}, 8'h00);
  endtask

  task automatic month_case(input string req, input logic [7:0] yr,
                            input logic [7:0] mo, input logic [7:0] dy,
                            input logic [2:0] wk, input logic [7:0] eyr,
                            input logic [7:0] emo, input logic [7:0] edy,
                            input logic [2:0] ewk);
    set_date(yr, mo, dy, wk);
    set_time(8'h23, 1'b0, 8'h59, 8'h59);
    tk();
    chk_date(req, eyr, emo, edy, ewk);
  endtask

  // R5 and R6: month lengths, leap years, year wrap, weekday wrap
  task automatic t_months();
    month_case("R5", 8'h22, 8'h04, 8'h30, 3'd1, 8'h22, 8'h05, 8'h01, 3'd2);
    month_case("R5", 8'h22, 8'h05, 8'h30, 3'd1, 8'h22, 8'h05, 8'h31, 3'd2);
    month_case("R5", 8'h23, 8'h02, 8'h28, 3'd0, 8'h23, 8'h03, 8'h01, 3'd1);
    month_case("R5", 8'h24, 8'h02, 8'h28, 3'd0, 8'h24, 8'h02, 8'h29, 3'd1);
    month_case("R5", 8'h00, 8'h02, 8'h28, 3'd0, 8'h00, 8'h02, 8'h29, 3'd1);
    month_case("R5", 8'h24, 8'h02, 8'h29, 3'd3, 8'h24, 8'h03, 8'h01, 3'd4);
    month_case("R5", 8'h99, 8'h12, 8'h31, 3'd6, 8'h00, 8'h01, 8'h01, 3'd0);
    month_case("R6", 8'h19, 8'h09, 8'h30, 3'd6, 8'h19, 8'h10, 8'h01, 3'd0);
  endtask

  // R7: rounding adjust
  task automatic t_adjust();
    logic [3:0] v;
    set_time(8'h07, 1'b0, 8'h10, 8'h29);
    wr(4'hD, 4'b1000);
    chk_time("R7", 8'h07, 1'b0, 8'h10, 8'h00);
    set_time(8'h05, 1'b0, 8'h59, 8'h45);
    wr(4'hD, 4'b1000);
    chk_time("R7", 8'h06, 1'b0, 8'h00, 8'h00);
    set_time(8'h05, 1'b0, 8'h20, 8'h30);
    wr(4'hD, 4'b1000);
    chk_time("R7", 8'h05, 1'b0, 8'h21, 8'h00);
    rd(4'hD, v); chk("R7", "adjust reads 0", {4'h0, v}, 8'h00);
  endtask

  // R8: stop discards ticks
  task automatic t_stop();
    logic [3:0] v;
    set_time(8'h12, 1'b0, 8'h34, 8'h56);
    wr(4'hF, 4'b0110);
    tk(); tk();
    chk_time("R8", 8'h12, 1'b0, 8'h34, 8'h56);
    wr(4'hF, 4'b0100);
    cyc(); cyc();
    chk_time("R8", 8'h12, 1'b0, 8'h34, 8'h56);
    rd(4'hD, v); chk("R8", "no kept tick", {4'h0, v}, 8'h00);
    tk(); chk_time("R8", 8'h12, 1'b0, 8'h34, 8'h57);
  endtask

  // R9: clear pins seconds
  task automatic t_clear();
    set_time(8'h03, 1'b0, 8'h15, 8'h42);
    wr(4'hF, 4'b0101);
    cyc();
    chk_time("R9", 8'h03, 1'b0, 8'h15, 8'h00);
    tk(); tk();
    chk_time("R9", 8'h03, 1'b0, 8'h15, 8'h00);
    wr(4'hF, 4'b0100);
    tk(); chk_time("R9", 8'h03, 1'b0, 8'h15, 8'h01);
  endtask

  // R10: hold defers and keeps at most one tick
  task automatic t_hold();
    logic [3:0] v;
    set_time(8'h08, 1'b0, 8'h00, 8'h10);
    wr(4'hD, 4'b0001);
    tk(); cyc(); tk(); tk();
    chk_time("R10", 8'h08, 1'b0, 8'h00, 8'h10);
    rd(4'hD, v); chk("R10", "busy while held", {4'h0, v}, 8'h03);
    wr(4'hD, 4'b0000);
    chk_time("R10", 8'h08, 1'b0, 8'h00, 8'h10);
    cyc();
    chk_time("R10", 8'h08, 1'b0, 8'h00, 8'h11);
    rd(4'hD, v); chk("R10", "busy cleared", {4'h0, v}, 8'h00);
  endtask

  // R11: masked writes and tick colliding with a write
  task automatic t_writes();
    logic [3:0] v;
    wr(4'h9, 4'b1100); rd(4'h9, v); chk("R11", "month tens mask", {4'h0, v}, 8'h00);
    wr(4'hC, 4'b1010); rd(4'hC, v); chk("R11", "weekday mask", {4'h0, v}, 8'h02);
    wr(4'hE, 4'hF);    rd(4'hE, v); chk("R11", "spare reads 0", {4'h0, v}, 8'h00);
    wr(4'hF, 4'b1100); rd(4'hF, v); chk("R11", "ctrlF bit3", {4'h0, v}, 8'h04);
    wr(4'h7, 4'b1111); rd(4'h7, v); chk("R11", "day tens mask", {4'h0, v}, 8'h03);
    set_time(8'h01, 1'b0, 8'h02, 8'h03);
    wr_en = 1'b1; wr_addr = 4'hA; wr_data = 4'h7; tick_1hz = 1'b1;
    cyc();
    wr_en = 1'b0; tick_1hz = 1'b0;
    rd(4'hA, v); chk("R11", "year ones written", {4'h0, v}, 8'h07);
    chk_time("R11", 8'h01, 1'b0, 8'h02, 8'h03);
    cyc();
    chk_time("R11", 8'h01, 1'b0, 8'h02, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_midnight24();
    t_twelve();
    t_months();
    t_adjust();
    t_stop();
    t_clear();
    t_hold();
    t_writes();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule